// File: doc/BRIEF.md
# Selectable Serial Baud Clock Generator

This block turns a fixed 2 MHz system clock into 16x oversampling clock enables for two serial channels. A divide-by-13 prescaler sets the fastest rate, nominally 16 x 9600 baud. The true figure is about 153.8 kHz, against an ideal 153.6 kHz, because the exact ratio of 13.02 is rounded to 13. A binary counter clocked by the prescaler wrap halves that rate six times, down to 150 baud. The 110-baud rate has its own branch: a divide-by-22 counter that advances on each 2400-baud pulse.

Each channel has a static 3-bit rate select, in the role a board switch would play. The chosen tap drives both the transmit and the receive enable of that channel. Every output is a pulse one system clock wide, in the same clock domain as the rest of the block. No derived clocks are made. All taps come from one shared counter state, so every rate keeps a fixed phase relative to reset. A select change therefore never produces an off-grid pulse.

Top module: `baud_clk_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, every counter clears and all transmit and receive enables are low in the following cycle.
- R2: With select code 0 (9600 baud), a channel pulses every 13 clocks. Counting the first rising edge with `rst_n` high as edge 1, its first pulse is visible right after edge 13.
- R3: Select codes 1 to 6 give 4800, 2400, 1200, 600, 300 and 150 baud. Code k gives a period of 13·2^k clocks, and the first pulse follows edge 13·2^k.
- R4: Select code 7 gives 110 baud with a period of 1144 clocks (22 periods of the 2400 tap). Every such pulse falls on a cycle where the 2400-baud tap also pulses.
- R5: Every enable pulse is exactly one clock wide.
- R6: The two channels select rates independently, and a select on one channel has no effect on the other channel's enables.
- R7: A channel's transmit enable and receive enable are identical in every cycle.
- R8: After a select change, the next pulse is the next pulse of the newly selected tap, which keeps its phase since reset. No other pulse appears in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2 MHz system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_rate_sel | input | 6 | Rate select codes, channel 0 in bits [2:0], channel 1 in bits [5:3] |
| tx_clk_en | output | 2 | Per-channel transmit clock enable pulse |
| rx_clk_en | output | 2 | Per-channel receive clock enable pulse |

## Verification
The main function is tested in several ways. Each code is held steady on one channel while the other channel runs a different code. This separates errors in the halving chain from errors in the per-channel select path, and shows that one channel cannot disturb the other. The fastest and slowest codes run together, which exposes any miscount in the prescaler and any miscount in the divide-by-22 branch in the same run. Selects are also changed in the middle of a period, both from fast to slow and from slow to fast. This shows whether the new tap keeps its phase from reset or restarts. A reset in the middle of the run then checks that every counter returns to its cleared phase.

// File: rtl/baud_pkg.sv
// Shared constants for the baud clock generator.
// Assumes a 2 MHz reference and 16x oversampling taps.
package baud_pkg;
    localparam int PRE_DIV_DEF   = 13;  // reference clocks per 9600-baud 16x tick
    localparam int HALVINGS_DEF  = 6;   // halving stages: 4800 down to 150
    localparam int SLOW_DIV_DEF  = 22;  // divide ratio of the 110-baud branch
    localparam int SLOW_SRC_DEF  = 2;   // tap feeding the branch (2400 baud)
    localparam int SEL_W         = 3;   // width of one channel's rate select
    localparam int NUM_CHAN_DEF  = 2;   // serial channels served
endpackage

// File: rtl/baud_prescaler.sv
// Prescaler: counts 0..DIV-1 on every clock and flags the cycle in which the
// count sits at DIV-1 (the wrap). Assumes DIV >= 2.
module baud_prescaler #(
    parameter int DIV = baud_pkg::PRE_DIV_DEF
) (
    input  logic clk,
    input  logic rst_n,
    output logic wrap_o
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Step the count, returning to zero after the last value.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end

    assign wrap_o = (cnt_q == LAST);

    // R2
    pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R2
    pre_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R2
    pre_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == LAST) |=> (cnt_q == '0));
endmodule

// File: rtl/baud_halving_chain.sv
// Halving chain: a binary counter advanced by the prescaler wrap. Tap i is
// high in a wrap cycle whose lower i counter bits are all ones, so tap i
// pulses at 1/2^i of the wrap rate. All taps are combinational and share one
// phase.
module baud_halving_chain #(
    parameter int STAGES = baud_pkg::HALVINGS_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wrap_i,
    output logic [STAGES:0] tap_o
);
    logic [STAGES-1:0] half_q;
    logic [STAGES:0]   run;

    // Count prescaler wraps.
    always_ff @(posedge clk) begin
        if (!rst_n)      half_q <= '0;
        else if (wrap_i) half_q <= half_q + 1'b1;
    end

    assign run[0] = wrap_i;
    generate
        for (genvar i = 1; i <= STAGES; i++) begin : g_tap
            assign run[i] = run[i-1] & half_q[i-1];
        end
    endgenerate
    assign tap_o = run;

    // R3
    half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_i |=> $stable(half_q));

    // R3
    half_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> (half_q == $past(half_q) + 1'b1));
endmodule

// File: rtl/baud_slow_divider.sv
// Slow branch: divides a source tap by DIV. It advances only on source
// pulses, so it stays in the system clock domain. The output is high in the
// source pulse that completes each group of DIV source pulses.
module baud_slow_divider #(
    parameter int DIV = baud_pkg::SLOW_DIV_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_en_i,
    output logic slow_o
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Count source pulses modulo DIV.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (src_en_i)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    assign slow_o = src_en_i & (cnt_q == LAST);

    // R4
    slow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R4
    slow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !src_en_i |=> $stable(cnt_q));
endmodule

// File: rtl/baud_chan_sel.sv
// Per-channel select: registers the tap chosen by a static select code. One
// register feeds both the transmit and the receive enable. Assumes the tap
// vector has 2^SEL_W entries.
module baud_chan_sel #(
    parameter int SEL_W = baud_pkg::SEL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic [2**SEL_W-1:0] taps_i,
    input  logic                wrap_i,
    output logic                tx_en_o,
    output logic                rx_en_o
);
    logic en_q;

    // Latch the selected tap for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= taps_i[sel_i];
    end

    assign tx_en_o = en_q;
    assign rx_en_o = en_q;

    // R1
    chan_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !en_q);

    // R5
    chan_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> !en_q);

    // R8
    chan_grid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |-> $past(wrap_i));
endmodule

// File: rtl/baud_clk_gen.sv
// Top: a shared prescaler, halving chain and slow branch build 2^SEL_W taps.
// Each channel selects one tap for its transmit and receive enables.
// Assumes the select codes are static apart from rare changes.
module baud_clk_gen #(
    parameter int NUM_CHAN = baud_pkg::NUM_CHAN_DEF,
    parameter int PRE_DIV  = baud_pkg::PRE_DIV_DEF,
    parameter int SLOW_DIV = baud_pkg::SLOW_DIV_DEF,
    parameter int SLOW_SRC = baud_pkg::SLOW_SRC_DEF
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_CHAN*baud_pkg::SEL_W-1:0] chan_rate_sel,
    output logic [NUM_CHAN-1:0]                tx_clk_en,
    output logic [NUM_CHAN-1:0]                rx_clk_en
);
    localparam int SW     = baud_pkg::SEL_W;
    localparam int NTAPS  = 2**SW;
    localparam int STAGES = NTAPS - 2;

    logic              wrap;
    logic [STAGES:0]   half_taps;
    logic              slow;
    logic [NTAPS-1:0]  taps;

    baud_prescaler #(.DIV(PRE_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .wrap_o(wrap));

    baud_halving_chain #(.STAGES(STAGES)) u_half (
        .clk(clk), .rst_n(rst_n), .wrap_i(wrap), .tap_o(half_taps));

    baud_slow_divider #(.DIV(SLOW_DIV)) u_slow (
        .clk(clk), .rst_n(rst_n), .src_en_i(half_taps[SLOW_SRC]),
        .slow_o(slow));

    assign taps = {slow, half_taps};

    generate
        for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
            baud_chan_sel #(.SEL_W(SW)) u_sel (
                .clk(clk), .rst_n(rst_n),
                .sel_i(chan_rate_sel[c*SW +: SW]),
                .taps_i(taps), .wrap_i(wrap),
                .tx_en_o(tx_clk_en[c]), .rx_en_o(rx_clk_en[c]));
        end
    endgenerate

    // R4
    slow_on_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slow |-> half_taps[SLOW_SRC]);
endmodule

// File: tb/baud_clk_gen_tb.sv
// Scoreboard bench: a predictor queues the expected enables for each edge,
// and a monitor pops them and compares at the falling edge.
module baud_clk_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel_a = 3'd0;
    logic [2:0] sel_b = 3'd7;
    logic [1:0] tx_en, rx_en;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  cyc     = 0;
    bit  chg_a   = 1'b0;
    bit  chg_b   = 1'b0;
    bit  done    = 1'b0;
    logic [1:0] prev_tx = 2'b00;

    logic [1:0] exp_q[$];
    string      tag_a_q[$];
    string      tag_b_q[$];

    always #2 clk = ~clk;

    baud_clk_gen dut_i (
        .clk(clk), .rst_n(rst_n), .chan_rate_sel({sel_b, sel_a}),
        .tx_clk_en(tx_en), .rx_clk_en(rx_en));

    // Period of each code: 13*2^k for codes 0..6, 1144 for code 7.
    function automatic int period(input logic [2:0] s);
        return (s == 3'd7) ? 13 * 4 * 22 : (13 << s);
    endfunction

    function automatic string code_tag(input logic [2:0] s);
        if (s == 3'd0) return "R2";
        if (s == 3'd7) return "R4";
        return "R3";
    endfunction

    // Predictor: edge count since reset release picks the expected enables.
    int n_edge = 0;
    always @(posedge clk) begin
        logic [1:0] e;
        string ta, tb;
        if (!rst_n) begin
            n_edge = 0;
            e = 2'b00;
            ta = "R1";
            tb = "R1";
        end else begin
            n_edge = n_edge + 1;
            e[0] = (n_edge % period(sel_a)) == 0;
            e[1] = (n_edge % period(sel_b)) == 0;
            ta = chg_a ? "R8" : code_tag(sel_a);
            tb = chg_b ? "R8" : "R6";
            if (e[0]) chg_a = 1'b0;
            if (e[1]) chg_b = 1'b0;
        end
        exp_q.push_back(e);
        tag_a_q.push_back(ta);
        tag_b_q.push_back(tb);
    end

    // Monitor: compare outputs against the queued items.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [1:0] e;
            string ta, tb;
            e  = exp_q.pop_front();
            ta = tag_a_q.pop_front();
            tb = tag_b_q.pop_front();
            n_tests++;
            if (tx_en[0] !== e[0]) begin
                n_fail++;
                $display("FAIL %s ch0 tx actual=%b expected=%b", ta, tx_en[0], e[0]);
            end
            n_tests++;
            if (tx_en[1] !== e[1]) begin
                n_fail++;
                $display("FAIL %s ch1 tx actual=%b expected=%b", tb, tx_en[1], e[1]);
            end
            n_tests++; // R7
            if (rx_en !== tx_en) begin
                n_fail++;
                $display("FAIL R7 rx actual=%b expected=%b", rx_en, tx_en);
            end
            n_tests++; // R5
            if ((prev_tx & tx_en) != 2'b00) begin
                n_fail++;
                $display("FAIL R5 two-cycle pulse actual=%b expected=00", prev_tx & tx_en);
            end
            prev_tx = tx_en;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_fail++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic set_sel(input logic [2:0] a, input logic [2:0] b);
        @(negedge clk);
        if (a != sel_a) chg_a = 1'b1;
        if (b != sel_b) chg_b = 1'b1;
        sel_a = a;
        sel_b = b;
    endtask

    task automatic wait_cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic do_reset(input int k);
        @(negedge clk);
        rst_n = 1'b0;
        chg_a = 1'b0;
        chg_b = 1'b0;
        wait_cyc(k);
        rst_n = 1'b1;
    endtask

    initial begin
        // R1: reset state, then fastest and slowest rates together (R2, R4).
        do_reset(5);
        wait_cyc(2400);
        // R3: each halved rate on channel 0 while channel 1 keeps 110 (R6).
        for (int k = 1; k <= 6; k++) begin
            set_sel(3'(k), 3'd7);
            wait_cyc(1700);
        end
        // R6: swap roles, channel 1 sweeps while channel 0 holds 9600.
        for (int k = 0; k <= 6; k++) begin
            set_sel(3'd0, 3'(k));
            wait_cyc(900);
        end
        // R8: changes in the middle of a period, slow to fast and back.
        set_sel(3'd6, 3'd1);
        wait_cyc(417);
        set_sel(3'd0, 3'd5);
        wait_cyc(31);
        set_sel(3'd7, 3'd2);
        wait_cyc(2500);
        set_sel(3'd3, 3'd7);
        wait_cyc(1300);
        // R1: reset mid-run restarts every phase.
        do_reset(3);
        wait_cyc(2400);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule